// File: doc/BRIEF.md
# Checked Array Element Access Engine

This block sits on the memory side of a stack processor. It carries out one array element load or store as a single request, and does every safety check in hardware. A request supplies an array reference and an element index. A store also supplies the word to write. The engine does the following in order:

1. It rejects a zero reference.
2. It fetches the array length from the word just after the reference.
3. It range-checks the index with a sign test.
4. It reads the reference word itself to obtain the base of the element storage.
5. It issues the element read or write at base plus index.

The processor issues a request and then waits while the engine's busy output is high. When busy falls, the processor takes the loaded word, or it sees an exception pulse. The engine drives a single-port, word-addressed memory bus with one read strobe, one write strobe and a busy input. Memory busy rises one cycle after a strobe, so the engine never samples it in the cycle that follows its own strobe. At most one transaction is outstanding at any time.

Top module: `arr_access_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, busy_o, mem_rd, mem_wr, done_o, npe_o and oob_o are all low.
- R2: A request with a zero reference produces a one-cycle npe_o pulse in the cycle after the request. No strobe is issued and busy_o stays low. The null check wins over the range check, whatever the index is.
- R3: A request with a nonzero reference first issues a read strobe, in the cycle after the request, at address reference+1.
- R4: The length word L and the index i are treated as 32-bit two's complement values. The access is out of range when bit 31 of ((L-1-i) OR i) is set. In that case oob_o pulses one cycle after the length word returns, and no further strobe follows.
- R5: After an in-range length check, the engine reads the word at the reference address to get a base pointer. It then strobes the element access at base+index.
- R6: A load (req_load high) ends with a one-cycle done_o pulse. In that same cycle rdata_o holds the word read at base+index.
- R7: A store (req_store high, req_load low) writes val_in to base+index with a write strobe and ends with a done_o pulse.
- R8: Each access completes in the first cycle, two or more cycles after its strobe, in which mem_busy is low. The next strobe follows in the cycle after that.
- R9: busy_o is high from the cycle after an accepted request until the cycle in which the done, npe or oob pulse appears, where it is low. Requests that arrive while busy_o is high are ignored.
- R10: done_o, npe_o and oob_o are one-cycle pulses, and at most one of them is high at a time. mem_wr is never high while npe_o or oob_o is high.
- R11: mem_rd and mem_wr are never high together. Neither is high while mem_busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_load | input | 1 | Start a checked element load |
| req_store | input | 1 | Start a checked element store (load wins if both) |
| ref_in | input | DW | Array reference |
| idx_in | input | DW | Element index, two's complement |
| val_in | input | DW | Word to store |
| busy_o | output | 1 | Operation in progress |
| rdata_o | output | DW | Loaded element word |
| done_o | output | 1 | Pulse: load or store finished |
| npe_o | output | 1 | Pulse: zero reference |
| oob_o | output | 1 | Pulse: index out of range |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_rdata | input | DW | Memory read data, valid once mem_busy is low |
| mem_busy | input | 1 | Memory busy, rises the cycle after a strobe |

## Verification
Take the request as cycle 0 and a memory busy time of LAT cycles. Access k is strobed in cycle 1+k*(2+LAT). The final pulse lands in cycle 1+n*(2+LAT), where n is 0 for a null reference, 1 for an out-of-range index and 3 for a completed access. The loaded word therefore appears in cycle 7+3*LAT. The bench derives these cycle numbers for each request from the requirements alone, using its own memory contents to decide the outcome. It then compares busy_o, both strobes, the strobed address and write data, and all three pulses at every falling edge from the request to one cycle past the pulse. It does this with LAT set to 1 and to 3, and with a stray request injected mid-operation.

// File: rtl/arr_pkg.sv
package arr_pkg;

  // Controller sequence: issue / wait pairs for the three dependent accesses
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEN_ISS,
    ST_LEN_WT,
    ST_HND_ISS,
    ST_HND_WT,
    ST_ELM_ISS,
    ST_ELM_WT
  } step_t;

  // Bus port phase: the gap phase keeps memory busy from being sampled
  // in the cycle right after a strobe
  typedef enum logic [1:0] {
    PT_IDLE,
    PT_GAP,
    PT_WAIT
  } port_t;

endpackage

// File: rtl/arr_bound_chk.sv
module arr_bound_chk #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] len_word,
  input  logic [DW-1:0] idx_word,
  output logic          out_of_range
);

  localparam int SB = DW - 1;

  logic [DW-1:0] slack;

  // Sign of (len-1-idx) catches idx >= len; sign of idx catches idx < 0
  always_comb begin
    slack        = len_word - {{(DW-1){1'b0}}, 1'b1} - idx_word;
    out_of_range = slack[SB] | idx_word[SB];
  end

endmodule

// File: rtl/arr_bus_port.sv
module arr_bus_port
  import arr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_wr,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_busy,
  output logic          acc_done,
  output logic [DW-1:0] acc_data
);

  port_t pst, pst_nx;
  logic  pst_en;

  always_comb begin
    mem_addr  = start_addr;
    mem_wdata = start_wdata;
    mem_rd    = start & ~start_wr;
    mem_wr    = start & start_wr;
    acc_done  = (pst == PT_WAIT) & ~mem_busy;
    acc_data  = mem_rdata;
  end

  always_comb begin
    pst_nx = pst;
    case (pst)
      PT_IDLE: if (start)     pst_nx = PT_GAP;
      PT_GAP:                 pst_nx = PT_WAIT;
      PT_WAIT: if (!mem_busy) pst_nx = PT_IDLE;
      default:                pst_nx = PT_IDLE;
    endcase
    pst_en = (pst_nx != pst);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pst <= PT_IDLE;
    else if (pst_en) pst <= pst_nx;
  end

endmodule

// File: rtl/arr_ctrl.sv
module arr_ctrl
  import arr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_load,
  input  logic          req_store,
  input  logic [DW-1:0] ref_in,
  input  logic [DW-1:0] idx_in,
  input  logic [DW-1:0] val_in,
  input  logic          acc_done,
  input  logic [DW-1:0] acc_data,
  input  logic          oob_hit,
  output logic [DW-1:0] idx_q,
  output logic          start,
  output logic          start_wr,
  output logic [AW-1:0] start_addr,
  output logic [DW-1:0] start_wdata,
  output logic          busy_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic          npe_o,
  output logic          oob_o
);

  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  step_t         st, st_nx;
  logic [DW-1:0] ref_q, val_q, base_q;
  logic          is_st_q;
  logic          cap_req, cap_base, fin_done, fin_npe, fin_oob, st_en;
  logic [DW-1:0] addr_full;

  always_comb begin
    st_nx     = st;
    start     = 1'b0;
    start_wr  = 1'b0;
    addr_full = ref_q + ONE;
    cap_req   = 1'b0;
    cap_base  = 1'b0;
    fin_done  = 1'b0;
    fin_npe   = 1'b0;
    fin_oob   = 1'b0;
    case (st)
      ST_IDLE: begin
        if (req_load || req_store) begin
          if (ref_in == '0) begin
            fin_npe = 1'b1;
          end else begin
            cap_req = 1'b1;
            st_nx   = ST_LEN_ISS;
          end
        end
      end
      ST_LEN_ISS: begin
        start     = 1'b1;
        addr_full = ref_q + ONE;
        st_nx     = ST_LEN_WT;
      end
      ST_LEN_WT: begin
        if (acc_done) begin
          if (oob_hit) begin
            fin_oob = 1'b1;
            st_nx   = ST_IDLE;
          end else begin
            st_nx   = ST_HND_ISS;
          end
        end
      end
      ST_HND_ISS: begin
        start     = 1'b1;
        addr_full = ref_q;
        st_nx     = ST_HND_WT;
      end
      ST_HND_WT: begin
        if (acc_done) begin
          cap_base = 1'b1;
          st_nx    = ST_ELM_ISS;
        end
      end
      ST_ELM_ISS: begin
        start     = 1'b1;
        start_wr  = is_st_q;
        addr_full = base_q + idx_q;
        st_nx     = ST_ELM_WT;
      end
      ST_ELM_WT: begin
        if (acc_done) begin
          fin_done = 1'b1;
          st_nx    = ST_IDLE;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
    st_en       = (st_nx != st);
    start_addr  = addr_full[AW-1:0];
    start_wdata = val_q;
    busy_o      = (st != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st <= ST_IDLE;
    else if (st_en) st <= st_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= '0;
      idx_q   <= '0;
      val_q   <= '0;
      is_st_q <= 1'b0;
    end else if (cap_req) begin
      ref_q   <= ref_in;
      idx_q   <= idx_in;
      val_q   <= val_in;
      is_st_q <= req_store & ~req_load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        base_q <= '0;
    else if (cap_base) base_q <= acc_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rdata_o <= '0;
    else if (fin_done && !is_st_q)  rdata_o <= acc_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      npe_o  <= 1'b0;
      oob_o  <= 1'b0;
    end else begin
      done_o <= fin_done;
      npe_o  <= fin_npe;
      oob_o  <= fin_oob;
    end
  end

endmodule

// File: rtl/arr_access_engine.sv
module arr_access_engine #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_load,
  input  logic          req_store,
  input  logic [DW-1:0] ref_in,
  input  logic [DW-1:0] idx_in,
  input  logic [DW-1:0] val_in,
  output logic          busy_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic          npe_o,
  output logic          oob_o,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_busy
);

  logic          start, start_wr, acc_done, oob_hit;
  logic [AW-1:0] start_addr;
  logic [DW-1:0] start_wdata, acc_data, idx_q;

  arr_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_load    (req_load),
    .req_store   (req_store),
    .ref_in      (ref_in),
    .idx_in      (idx_in),
    .val_in      (val_in),
    .acc_done    (acc_done),
    .acc_data    (acc_data),
    .oob_hit     (oob_hit),
    .idx_q       (idx_q),
    .start       (start),
    .start_wr    (start_wr),
    .start_addr  (start_addr),
    .start_wdata (start_wdata),
    .busy_o      (busy_o),
    .rdata_o     (rdata_o),
    .done_o      (done_o),
    .npe_o       (npe_o),
    .oob_o       (oob_o)
  );

  arr_bound_chk #(.DW(DW)) u_bound (
    .len_word     (acc_data),
    .idx_word     (idx_q),
    .out_of_range (oob_hit)
  );

  arr_bus_port #(.DW(DW), .AW(AW)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_wr    (start_wr),
    .start_addr  (start_addr),
    .start_wdata (start_wdata),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_rdata   (mem_rdata),
    .mem_busy    (mem_busy),
    .acc_done    (acc_done),
    .acc_data    (acc_data)
  );

endmodule

// File: rtl/arr_access_chk.sv
module arr_access_chk #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_load,
  input logic          req_store,
  input logic [DW-1:0] ref_in,
  input logic          busy_o,
  input logic          done_o,
  input logic          npe_o,
  input logic          oob_o,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          mem_busy
);

  logic          acc_new;
  logic [AW-1:0] ref_p1;
  logic [DW-1:0] ref_sum;

  always_comb begin
    acc_new = !busy_o && (req_load || req_store) && (ref_in != '0);
    ref_sum = ref_in + {{(DW-1){1'b0}}, 1'b1};
    ref_p1  = ref_sum[AW-1:0];
  end

  AST_NULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && (req_load || req_store) && ref_in == '0) |=> (npe_o && !busy_o && !mem_rd && !mem_wr)); // R2

  AST_LEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    acc_new |=> (mem_rd && !mem_wr && busy_o && mem_addr == $past(ref_p1))); // R3

  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |=> !(mem_rd || mem_wr || done_o || oob_o)); // R8

  AST_IDLE_AT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || npe_o || oob_o) |-> !busy_o); // R9

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !$past(busy_o)) |-> $past(acc_new)); // R9

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done_o, npe_o, oob_o}) <= 1); // R10

  AST_FLAG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || npe_o || oob_o) |=> !(done_o || npe_o || oob_o)); // R10

  AST_NO_WR_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (npe_o || oob_o) |-> !mem_wr); // R10

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr})); // R11

  AST_NO_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_busy |-> !(mem_rd || mem_wr)); // R11

endmodule

bind arr_access_engine arr_access_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_load  (req_load),
  .req_store (req_store),
  .ref_in    (ref_in),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .npe_o     (npe_o),
  .oob_o     (oob_o),
  .mem_addr  (mem_addr),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_busy  (mem_busy)
);

// File: tb/tb_arr_access_engine.sv
module tb_arr_access_engine;

  logic        clk, rst_n;
  logic        req_load, req_store;
  logic [31:0] ref_in, idx_in, val_in;
  logic        busy_o, done_o, npe_o, oob_o;
  logic [31:0] rdata_o, mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, mem_busy;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int lat = 1;

  // Bench memory: 64 words, indexed by the low six address bits
  logic [31:0] mem [64];
  int          bcnt;
  logic [31:0] rd_q;
  logic        tb_we;
  logic [5:0]  tb_a;
  logic [31:0] tb_d;

  arr_access_engine dut (
    .clk(clk), .rst_n(rst_n), .req_load(req_load), .req_store(req_store),
    .ref_in(ref_in), .idx_in(idx_in), .val_in(val_in), .busy_o(busy_o),
    .rdata_o(rdata_o), .done_o(done_o), .npe_o(npe_o), .oob_o(oob_o),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_rdata(mem_rdata), .mem_busy(mem_busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign mem_busy  = (bcnt != 0);
  assign mem_rdata = rd_q;

  always @(posedge clk) begin
    if (mem_rd || mem_wr) begin
      bcnt <= lat;
      if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;
      else        rd_q <= mem[mem_addr[5:0]];
    end else begin
      if (bcnt > 0) bcnt <= bcnt - 1;
      if (tb_we)    mem[tb_a] <= tb_d;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_a = a[5:0]; tb_d = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  // Cycle-accurate expectation of one request, compared every cycle
  task automatic run_op(input bit is_st, input logic [31:0] r, input logic [31:0] idx,
                        input logic [31:0] val, input int ign_at);
    logic [31:0] len, base, ea, ld_exp;
    logic [31:0] addrs [3];
    bit npe, oob;
    int nacc, endc;
    npe  = (r == 0);
    len  = mem[r[5:0] + 6'd1];
    base = mem[r[5:0]];
    ea   = base + idx;
    ld_exp = mem[ea[5:0]];
    oob  = !npe && ($signed(idx) < 0 || $signed(idx) >= $signed(len));
    nacc = npe ? 0 : (oob ? 1 : 3);
    endc = nacc * (2 + lat) + 1;
    addrs[0] = r + 1; addrs[1] = r; addrs[2] = ea;
    @(negedge clk);
    req_load = !is_st; req_store = is_st; ref_in = r; idx_in = idx; val_in = val;
    for (int c = 1; c <= endc + 1; c++) begin
      bit iss, ex_rd, ex_wr;
      int k;
      @(negedge clk);
      if (c == 1 || c == ign_at + 1) begin req_load = 1'b0; req_store = 1'b0; end
      iss = 1'b0; k = 0;
      for (int j = 0; j < nacc; j++) if (c == 1 + j * (2 + lat)) begin iss = 1'b1; k = j; end
      ex_rd = iss && !(is_st && k == 2);
      ex_wr = iss && is_st && k == 2;
      chk(busy_o == (c < endc), "R9 busy", 32'(busy_o), 32'(c < endc));
      chk(mem_rd == ex_rd, "R8 rd strobe timing", 32'(mem_rd), 32'(ex_rd));
      chk(mem_wr == ex_wr, "R7 wr strobe", 32'(mem_wr), 32'(ex_wr));
      if (iss && k == 0) chk(mem_addr == addrs[0], "R3 length addr", mem_addr, addrs[0]);
      if (iss && k != 0) chk(mem_addr == addrs[k], "R5 access addr", mem_addr, addrs[k]);
      if (ex_wr) chk(mem_wdata == val, "R7 wdata", mem_wdata, val);
      chk(npe_o == (c == endc && npe), "R2 npe", 32'(npe_o), 32'(c == endc && npe));
      chk(oob_o == (c == endc && oob), "R4 oob", 32'(oob_o), 32'(c == endc && oob));
      chk(done_o == (c == endc && !npe && !oob), "R6 done", 32'(done_o), 32'(c == endc && !npe && !oob));
      if (c == endc && !npe && !oob && !is_st) chk(rdata_o == ld_exp, "R6 rdata", rdata_o, ld_exp);
      if (c == ign_at) begin req_store = 1'b1; ref_in = 32'h0; idx_in = 32'h5; end
    end
    if (is_st && !npe && !oob) chk(mem[ea[5:0]] == val, "R7 stored word", mem[ea[5:0]], val);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    rst_n = 1'b0; req_load = 1'b0; req_store = 1'b0;
    ref_in = '0; idx_in = '0; val_in = '0;
    tb_we = 1'b0; tb_a = '0; tb_d = '0; bcnt = 0; rd_q = '0;
    // Array A at 8: length 4, data at 40
    poke(8, 32'd40); poke(9, 32'd4);
    for (int i = 0; i < 6; i++) poke(40 + i, 32'hA000_0000 + 32'(i));
    // Array B at 16: length 0
    poke(16, 32'd50); poke(17, 32'd0);
    // Array C at 20: length 1, data at 30
    poke(20, 32'd30); poke(21, 32'd1); poke(30, 32'hC0FF_EE01);
    @(negedge clk);
    chk({busy_o, mem_rd, mem_wr, done_o, npe_o, oob_o} == 6'b0, "R1 in reset", 32'({busy_o, mem_rd, mem_wr}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy_o, mem_rd, mem_wr, done_o, npe_o, oob_o} == 6'b0, "R1 after reset", 32'({busy_o, mem_rd, mem_wr}), 0);

    lat = 1;
    run_op(1'b0, 32'd8, 32'd0, 32'd0, 0);              // R6 first element
    run_op(1'b0, 32'd8, 32'd3, 32'd0, 0);              // R4 last valid index
    run_op(1'b0, 32'd8, 32'd4, 32'd0, 0);              // R4 index equals length
    run_op(1'b0, 32'd8, 32'hFFFF_FFFF, 32'd0, 0);      // R4 negative index
    run_op(1'b1, 32'd8, 32'd2, 32'hDEAD_BEEF, 0);      // R7 store
    run_op(1'b0, 32'd8, 32'd2, 32'd0, 0);              // R6 reload stored word
    keep = mem[45];
    run_op(1'b1, 32'd8, 32'd5, 32'h1234_5678, 0);      // R4 store out of range
    chk(mem[45] == keep, "R4 no write on oob", mem[45], keep);
    run_op(1'b0, 32'd0, 32'h8000_0000, 32'd0, 0);      // R2 null wins over range
    run_op(1'b1, 32'd0, 32'd1, 32'h5, 0);              // R2 null store
    run_op(1'b0, 32'd16, 32'd0, 32'd0, 0);             // R4 zero length
    lat = 3;
    run_op(1'b0, 32'd20, 32'd0, 32'd0, 2);             // R8 slow memory, R9 ignored request
    run_op(1'b1, 32'd8, 32'd1, 32'h0BAD_F00D, 4);      // R9 ignored request during store
    run_op(1'b0, 32'd8, 32'd1, 32'd0, 0);              // R7 read back
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, npe_o, oob_o} == 4'b0, "R9 idle at end", 32'({busy_o, done_o}), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule